// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Address Filter

This block sits on the receive path of a UART, after the deserializer and before the receive FIFO. Every received character arrives with eight data bits and a ninth bit. In normal operation the filter is transparent: each character is handed to the FIFO one clock later. In multidrop operation the ninth bit no longer carries parity. Instead it marks a character as a station address (1) or as payload data (0). A receive gate flag, SM2, decides whether payload characters reach the FIFO.

The filter can select its own node in hardware. A received address is compared against a programmable slave address, and a mask picks which bit positions take part in the compare. A received address whose compared positions are all ones is a broadcast and is also accepted. When auto-addressing is on, an accepted address opens the gate, a rejected one closes it, and neither is written to the FIFO. The host then never sees address traffic. When auto-addressing is off, every address character goes to the FIFO and closes the gate again. The host inspects the address and opens the gate with a clear strobe.

Top module: `mdrop_filter`

## Requirements
- R1: After synchronous reset, `sm2` is 1 and `fifo_wr` is 0.
- R2: With `mdrop_en`=0, every character presented with `rx_valid` is written: `fifo_wr` is 1 in the next cycle and `fifo_char` equals {`rx_bit9`, `rx_data`}. `sm2` keeps its value.
- R3: With `mdrop_en`=1, a data character (`rx_bit9`=0) received while `sm2` is 1 produces no FIFO write.
- R4: With `mdrop_en`=1, a data character received while `sm2` is 0 is written in the next cycle as {0, `rx_data`}.
- R5: With `mdrop_en`=1 and `auto_addr`=1, an address character (`rx_bit9`=1) that equals `slave_addr` in every bit where `addr_mask` is 1 clears `sm2` in the next cycle and is not written.
- R6: With `mdrop_en`=1 and `auto_addr`=1, an address character that is 1 in every bit where `addr_mask` is 1 (broadcast) clears `sm2` and is not written.
- R7: With `mdrop_en`=1 and `auto_addr`=1, an address character that matches neither the slave address nor the broadcast address sets `sm2` to 1 and is not written.
- R8: With `mdrop_en`=1 and `auto_addr`=0, an address character is written to the FIFO as {1, `rx_data`} and sets `sm2` to 1. Hardware never clears `sm2` in this mode.
- R9: A `host_clr_sm2` pulse makes `sm2` 0 in the next cycle. If a character that updates `sm2` arrives in the same cycle, the character's update wins.
- R10: Bits where `addr_mask` is 0 never affect the address compare. With `addr_mask`=0x00, every address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received data bits |
| rx_bit9 | input | 1 | Ninth received bit (address flag in multidrop) |
| mdrop_en | input | 1 | 1 selects multidrop operation |
| auto_addr | input | 1 | 1 selects hardware address recognition |
| slave_addr | input | 8 | This node's address |
| addr_mask | input | 8 | 1 marks bit positions that are compared |
| host_clr_sm2 | input | 1 | Host strobe that clears SM2 |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_char | output | 9 | Character written: {ninth bit, data} |
| sm2 | output | 1 | Receive gate flag; 1 discards data characters |

## Verification
The bench drives a sequence in which the gate state carries from one character to the next. It checks a masked match, a broadcast, and a miss. A comparator that ignores the mask or leaves out the broadcast term would leave the gate in the wrong state, and the data that follows would be dropped or leak through. It also checks data arriving before any address, which a design that resets the gate open would wrongly pass. It checks that turning multidrop off both passes everything and keeps the gate flag untouched. Two cases target the host clear: an isolated clear, and a clear that collides with a rejected address, where a wrong priority leaves the gate open. A zero mask checks that an empty compare accepts every address.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    localparam int CH_W = 8;

    typedef struct packed {
        logic            tag;
        logic [CH_W-1:0] val;
    } rx_char_t;

    typedef enum logic [1:0] {
        CK_PASS = 2'd0,
        CK_DATA = 2'd1,
        CK_ADDR = 2'd2
    } ch_kind_e;

    function automatic ch_kind_e kind_of(input logic md_on, input logic tag);
        if (!md_on)
            return CK_PASS;
        return tag ? CK_ADDR : CK_DATA;
    endfunction

endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify
    import mdrop_pkg::*;
(
    input  logic     md_on,
    input  rx_char_t ch,
    output ch_kind_e kind
);
    always_comb kind = kind_of(md_on, ch.tag);
endmodule

// File: rtl/mdrop_addr_match.sv
module mdrop_addr_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] own,
    input  logic [W-1:0] care,
    output logic         hit
);
    logic [W-1:0] own_ok;
    logic [W-1:0] bc_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign own_ok[i] = !care[i] || (val[i] == own[i]);
        assign bc_ok[i]  = !care[i] || val[i];
    end

    assign hit = (&own_ok) || (&bc_ok);
endmodule

// File: rtl/mdrop_gate.sv
module mdrop_gate
    import mdrop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  ch_kind_e kind,
    input  rx_char_t ch,
    input  logic     auto_on,
    input  logic     hit,
    input  logic     host_clr,
    output logic     wr,
    output rx_char_t wr_ch,
    output logic     gate
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate  <= 1'b1;
            wr    <= 1'b0;
            wr_ch <= '0;
        end else begin
            wr <= 1'b0;
            if (host_clr)
                gate <= 1'b0;
            if (valid) begin
                unique case (kind)
                    CK_PASS: begin
                        wr    <= 1'b1;
                        wr_ch <= ch;
                    end
                    CK_DATA: begin
                        if (!gate) begin
                            wr    <= 1'b1;
                            wr_ch <= ch;
                        end
                    end
                    CK_ADDR: begin
                        if (auto_on) begin
                            gate <= !hit;
                        end else begin
                            gate  <= 1'b1;
                            wr    <= 1'b1;
                            wr_ch <= ch;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !valid |=> !wr); // R2
    AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_PASS |=> wr && wr_ch == $past(ch)); // R2
    AST_NORMAL_GATE_HELD: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_PASS && !host_clr |=> gate == $past(gate)); // R2
    AST_DATA_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_DATA && gate |=> !wr); // R3
    AST_DATA_OPEN: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_DATA && !gate |=> wr); // R4
    AST_ADDR_HIT_OPENS: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_ADDR && auto_on && hit |=> !gate && !wr); // R5
    AST_ADDR_MISS_CLOSES: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_ADDR && auto_on && !hit |=> gate && !wr); // R7
    AST_MANUAL_ADDR: assert property (@(posedge clk) disable iff (rst)
        valid && kind == CK_ADDR && !auto_on |=> gate && wr); // R8
    AST_HOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        host_clr && !valid |=> !gate); // R9
endmodule

// File: rtl/mdrop_filter.sv
module mdrop_filter
    import mdrop_pkg::*;
#(
    parameter int DATA_W = CH_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              mdrop_en,
    input  logic              auto_addr,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              host_clr_sm2,
    output logic              fifo_wr,
    output logic [DATA_W:0]   fifo_char,
    output logic              sm2
);
    rx_char_t ch_in;
    rx_char_t ch_out;
    ch_kind_e kind;
    logic     addr_hit;

    assign ch_in = '{tag: rx_bit9, val: rx_data};

    mdrop_classify u_classify (
        .md_on (mdrop_en),
        .ch    (ch_in),
        .kind  (kind)
    );

    mdrop_addr_match #(.W(DATA_W)) u_match (
        .val  (rx_data),
        .own  (slave_addr),
        .care (addr_mask),
        .hit  (addr_hit)
    );

    mdrop_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .valid    (rx_valid),
        .kind     (kind),
        .ch       (ch_in),
        .auto_on  (auto_addr),
        .hit      (addr_hit),
        .host_clr (host_clr_sm2),
        .wr       (fifo_wr),
        .wr_ch    (ch_out),
        .gate     (sm2)
    );

    assign fifo_char = ch_out;

    AST_BCAST_OPENS: assert property (@(posedge clk) disable iff (rst)
        rx_valid && mdrop_en && auto_addr && rx_bit9
        && ((rx_data & addr_mask) == addr_mask) |=> !sm2); // R6
    AST_ZERO_MASK_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        rx_valid && mdrop_en && auto_addr && rx_bit9 && addr_mask == '0
        |=> !sm2); // R10
endmodule

// File: tb/mdrop_filter_tb.sv
`timescale 1ns/1ps
module mdrop_filter_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       mdrop_en;
    logic       auto_addr;
    logic [7:0] slave_addr;
    logic [7:0] addr_mask;
    logic       host_clr_sm2;
    logic       fifo_wr;
    logic [8:0] fifo_char;
    logic       sm2;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mdrop_filter u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .mdrop_en(mdrop_en), .auto_addr(auto_addr),
        .slave_addr(slave_addr), .addr_mask(addr_mask),
        .host_clr_sm2(host_clr_sm2), .fifo_wr(fifo_wr),
        .fifo_char(fifo_char), .sm2(sm2)
    );

    typedef struct packed {
        logic       v;
        logic       md;
        logic       au;
        logic [7:0] sa;
        logic [7:0] mk;
        logic       clr;
        logic       b9;
        logic [7:0] d;
        logic       ewr;
        logic       esm2;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b1,8'h5A,8'hF0,1'b0,1'b1,8'h33,1'b1,1'b1,8'd2},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b0,8'h11,1'b0,1'b1,8'd3},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b1,8'h5C,1'b0,1'b0,8'd5},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b0,8'h22,1'b1,1'b0,8'd4},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b1,8'h3A,1'b0,1'b1,8'd7},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b0,8'h44,1'b0,1'b1,8'd3},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b1,8'hF3,1'b0,1'b0,8'd6},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b0,8'h55,1'b1,1'b0,8'd4},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b0,1'b1,8'h00,1'b0,1'b1,8'd7},
        '{1'b1,1'b0,1'b1,8'h5A,8'hF0,1'b0,1'b0,8'h66,1'b1,1'b1,8'd2},
        '{1'b1,1'b1,1'b0,8'h5A,8'hF0,1'b0,1'b1,8'h77,1'b1,1'b1,8'd8},
        '{1'b0,1'b1,1'b0,8'h5A,8'hF0,1'b1,1'b0,8'h00,1'b0,1'b0,8'd9},
        '{1'b1,1'b1,1'b0,8'h5A,8'hF0,1'b0,1'b0,8'h88,1'b1,1'b0,8'd4},
        '{1'b1,1'b1,1'b0,8'h5A,8'hF0,1'b0,1'b1,8'h12,1'b1,1'b1,8'd8},
        '{1'b0,1'b1,1'b0,8'h5A,8'hF0,1'b0,1'b0,8'h00,1'b0,1'b1,8'd8},
        '{1'b1,1'b1,1'b1,8'h5A,8'h00,1'b0,1'b1,8'h00,1'b0,1'b0,8'd10},
        '{1'b1,1'b1,1'b1,8'h5A,8'hF0,1'b1,1'b1,8'h3A,1'b0,1'b1,8'd9}
    };

    task automatic chk(input int req, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_valid     = 1'b0;
        rx_data      = 8'h00;
        rx_bit9      = 1'b0;
        host_clr_sm2 = 1'b0;
    endtask

    initial begin : watchdog
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        idle_inputs();
        mdrop_en   = 1'b0;
        auto_addr  = 1'b0;
        slave_addr = 8'h00;
        addr_mask  = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(1, "sm2 after reset", {8'h0, sm2}, 9'h1);
        chk(1, "fifo_wr after reset", {8'h0, fifo_wr}, 9'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            rx_valid     = VECS[i].v;
            mdrop_en     = VECS[i].md;
            auto_addr    = VECS[i].au;
            slave_addr   = VECS[i].sa;
            addr_mask    = VECS[i].mk;
            host_clr_sm2 = VECS[i].clr;
            rx_bit9      = VECS[i].b9;
            rx_data      = VECS[i].d;
            @(negedge clk);
            idle_inputs();
            chk(int'(VECS[i].req), $sformatf("vector %0d fifo_wr", i),
                {8'h0, fifo_wr}, {8'h0, VECS[i].ewr});
            chk(int'(VECS[i].req), $sformatf("vector %0d sm2", i),
                {8'h0, sm2}, {8'h0, VECS[i].esm2});
            if (VECS[i].ewr)
                chk(int'(VECS[i].req), $sformatf("vector %0d fifo_char", i),
                    fifo_char, {VECS[i].b9, VECS[i].d});
        end

        // R9: isolated host clear, then a masked match with a don't-care bit (R10)
        host_clr_sm2 = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk(9, "sm2 after host clear", {8'h0, sm2}, 9'h0);
        mdrop_en = 1'b1; auto_addr = 1'b1;
        slave_addr = 8'hA5; addr_mask = 8'h0F;
        rx_valid = 1'b1; rx_bit9 = 1'b1; rx_data = 8'h35;
        @(negedge clk);
        idle_inputs();
        chk(10, "masked-off high nibble ignored", {8'h0, sm2}, 9'h0);
        rx_valid = 1'b1; rx_bit9 = 1'b1; rx_data = 8'hA4;
        @(negedge clk);
        idle_inputs();
        chk(7, "low nibble mismatch closes gate", {8'h0, sm2}, 9'h1);

        // R1: reset mid-run returns the gate to closed
        host_clr_sm2 = 1'b1;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(1, "sm2 after second reset", {8'h0, sm2}, 9'h1);
        chk(1, "fifo_wr after second reset", {8'h0, fifo_wr}, 9'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule